// File: doc/BRIEF.md
# Descriptor Table Register Load Unit

This unit carries out the two system instructions that load the global descriptor table register or the interrupt descriptor table register. The instruction selector comes from the reg field of the ModRM byte. A value of 2 picks the global table register and 3 picks the interrupt table register. When `start` is pulsed, the unit samples the processor mode, the operand size, the current privilege level, the LOCK-prefix flag, the segment-check results, a page-fault indication and the effective address of the memory operand.

The unit first runs the mode-dependent fault checks in a fixed priority order. If a fault is found, it reports one fault, with its vector and error code, and leaves both table registers untouched. If no fault is found, it fetches the memory operand in 16-bit beats over a valid/ready read port. It then extracts a 16-bit limit and a base address, masking the base according to the operand size and mode, and commits them to the selected register together with a one-cycle `done` pulse.

Top module: `dtr_load_unit`

## Requirements
- R1: After reset, both table registers hold limit 0 and base 0, and `busy`, `done`, `fault` and `rd_ready` are low.
- R2: The reg field value 2 updates only the global register and 3 updates only the interrupt register. Any other reg value raises the invalid-opcode fault (vector 6, no error code).
- R3: The stored limit is always operand bytes 0 and 1 (beat 0, little-endian).
- R4: Outside 64-bit mode with a 32-bit operand size (`op32`=1), three beats are read and the base is operand bytes 2..5, with base bits 63:32 zero.
- R5: Outside 64-bit mode with a 16-bit operand size (`op32`=0), the base is operand bytes 2..4. Base bits 63:24 are zero and operand byte 5 has no effect on any output.
- R6: In 64-bit mode (`cpu_mode`=3), five beats are read regardless of `op32`, and the base is operand bytes 2..9.
- R7: A LOCK prefix raises the invalid-opcode fault (vector 6, `fault_err_vld`=0) in every mode.
- R8: A privilege level other than 0 raises a general-protection fault (vector 13, error code 0) in protected (1), compatibility (2), 64-bit (3) and virtual-8086 (4) modes, and is not checked in real-address mode (0).
- R9: In 64-bit mode, an effective address whose bits 63..47 are not all equal raises a stack fault (vector 12, error 0) when `seg_is_ss`=1, and a general-protection fault (vector 13, error 0) otherwise.
- R10: In protected and compatibility modes, `seg_limit_err` raises a stack fault (12) through SS or a general-protection fault (13) otherwise, both with error code 0. A null selector (`seg_null`) on a non-SS segment raises a general-protection fault (13, error 0). In real mode, `seg_limit_err` raises the same vectors with `fault_err_vld`=0.
- R11: Faults take priority in this order: invalid opcode, then privilege, then address/segment, then page fault. A faulting instruction raises `done` and `fault` for one cycle starting one clock after `start`, issues no read, and changes neither register.
- R12: Outside real mode, `page_fault` raises vector 14 with `fault_err` equal to `pf_code`. In real mode it is ignored.
- R13: Beat i is requested at address `eff_addr`+2i with `rd_ready` high only while beats are outstanding. The register update and a one-cycle `done` (with `fault`=0) appear one clock after the edge that accepts the last beat. A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one load instruction |
| modrm_reg | input | 3 | ModRM reg field (2 global, 3 interrupt) |
| cpu_mode | input | 3 | 0 real, 1 protected, 2 compatibility, 3 64-bit, 4 virtual-8086 |
| op32 | input | 1 | 1 for 32-bit operand size, 0 for 16-bit |
| cpl | input | 2 | Current privilege level |
| lock_pfx | input | 1 | LOCK prefix present |
| seg_is_ss | input | 1 | Operand accessed through SS |
| seg_limit_err | input | 1 | Operand offset beyond segment limit |
| seg_null | input | 1 | Segment register holds a null selector |
| page_fault | input | 1 | Page fault on the operand access |
| pf_code | input | 16 | Page-fault error code |
| eff_addr | input | 64 | Linear address of the operand |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | 16 | Read data beat |
| rd_ready | output | 1 | Unit accepts a beat |
| rd_addr | output | 64 | Address of the beat requested |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion ended in a fault |
| fault_vec | output | 8 | Fault vector |
| fault_err_vld | output | 1 | Fault carries an error code |
| fault_err | output | 16 | Fault error code |
| gdt_limit | output | 16 | Global table limit |
| gdt_base | output | 64 | Global table base |
| idt_limit | output | 16 | Interrupt table limit |
| idt_base | output | 64 | Interrupt table base |

## Verification
A fault result is due on the first clock after `start`. A successful load shows no result until the beat that completes the operand has been accepted, and then its `done` pulse and new register value arrive one clock later. The bench model advances on the same edges the design does, so the checks never wait for a result. It records each accepted beat from its own stall pattern, predicts `rd_ready`, `rd_addr`, `done`, `fault` and both registers for the next cycle, and compares all of them at every falling edge. Stalls on `rd_valid` stretch the gather phase so that the due cycle moves with the handshake and not with a fixed count.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
   typedef enum logic [2:0] {
      MODE_REAL   = 3'd0,
      MODE_PROT   = 3'd1,
      MODE_COMPAT = 3'd2,
      MODE_LONG   = 3'd3,
      MODE_V86    = 3'd4
   } cpu_mode_e;

   localparam logic [7:0] VEC_UD = 8'd6;
   localparam logic [7:0] VEC_SS = 8'd12;
   localparam logic [7:0] VEC_GP = 8'd13;
   localparam logic [7:0] VEC_PF = 8'd14;

   localparam logic [2:0] SEL_GLOBAL = 3'd2;
   localparam logic [2:0] SEL_INTR   = 3'd3;

   typedef struct packed {
      logic        hit;
      logic [7:0]  vec;
      logic        err_vld;
      logic [15:0] err;
   } fault_t;
endpackage

// File: rtl/dtr_fault_check.sv
module dtr_fault_check
   import dtr_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int VA_BITS = 48
) (
   input  logic [2:0]        mode,
   input  logic [2:0]        reg_sel,
   input  logic [1:0]        cpl,
   input  logic              lock_pfx,
   input  logic              seg_is_ss,
   input  logic              seg_limit_err,
   input  logic              seg_null,
   input  logic              page_fault,
   input  logic [15:0]       pf_code,
   input  logic [ADDR_W-1:0] eff_addr,
   output fault_t            result
);
   localparam int TOP_BITS = ADDR_W - VA_BITS + 1;

   logic canonical;
   logic [TOP_BITS-1:0] upper;
   logic seg_mode, paged, bad_op;

   assign upper     = eff_addr[ADDR_W-1:VA_BITS-1];
   assign canonical = (&upper) | ~(|upper);
   assign seg_mode  = (mode == MODE_PROT) || (mode == MODE_COMPAT);
   assign paged     = (mode != MODE_REAL);
   assign bad_op    = lock_pfx || (mode > MODE_V86) ||
                      ((reg_sel != SEL_GLOBAL) && (reg_sel != SEL_INTR));

   always_comb begin
      result = '0;
      if (bad_op) begin
         result.hit = 1'b1;
         result.vec = VEC_UD;
      end else if (paged && (cpl != 2'd0)) begin
         result.hit     = 1'b1;
         result.vec     = VEC_GP;
         result.err_vld = 1'b1;
      end else if ((mode == MODE_LONG) && !canonical) begin
         result.hit     = 1'b1;
         result.vec     = seg_is_ss ? VEC_SS : VEC_GP;
         result.err_vld = 1'b1;
      end else if ((seg_mode || (mode == MODE_REAL)) && seg_limit_err) begin
         result.hit     = 1'b1;
         result.vec     = seg_is_ss ? VEC_SS : VEC_GP;
         result.err_vld = seg_mode;
      end else if (seg_mode && seg_null && !seg_is_ss) begin
         result.hit     = 1'b1;
         result.vec     = VEC_GP;
         result.err_vld = 1'b1;
      end else if (paged && page_fault) begin
         result.hit     = 1'b1;
         result.vec     = VEC_PF;
         result.err_vld = 1'b1;
         result.err     = pf_code;
      end
   end
endmodule

// File: rtl/dtr_gather.sv
module dtr_gather #(
   parameter  int BEAT_W    = 16,
   parameter  int ADDR_W    = 64,
   parameter  int MAX_BEATS = 5,
   localparam int CNT_W     = $clog2(MAX_BEATS + 1),
   localparam int BPB       = BEAT_W / 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          go,
   input  logic [CNT_W-1:0]              need,
   input  logic [ADDR_W-1:0]             base_addr,
   input  logic                          rd_valid,
   input  logic [BEAT_W-1:0]             rd_data,
   output logic                          rd_ready,
   output logic [ADDR_W-1:0]             rd_addr,
   output logic                          last_acc,
   output logic [MAX_BEATS*BEAT_W-1:0]   words
);
   logic              active_q;
   logic [CNT_W-1:0]  cnt_q, need_q;
   logic [ADDR_W-1:0] addr_q;
   logic              acc;

   assign rd_ready = active_q;
   assign acc      = active_q && rd_valid;
   assign last_acc = acc && (cnt_q == need_q - 1'b1);
   assign rd_addr  = addr_q + (ADDR_W'(cnt_q) * ADDR_W'(BPB));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         need_q   <= '0;
         addr_q   <= '0;
      end else if (go) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         need_q   <= need;
         addr_q   <= base_addr;
      end else if (acc) begin
         cnt_q <= cnt_q + 1'b1;
         if (last_acc) active_q <= 1'b0;
      end
   end

   for (genvar g = 0; g < MAX_BEATS; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) words[g*BEAT_W +: BEAT_W] <= '0;
         else if (acc && (cnt_q == CNT_W'(g))) words[g*BEAT_W +: BEAT_W] <= rd_data;
      end
   end

   // R13
   beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (cnt_q < need_q));
endmodule

// File: rtl/dtr_table_regs.sv
module dtr_table_regs #(
   parameter  int ADDR_W     = 64,
   parameter  int NUM_TABLES = 2,
   localparam int SEL_W      = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [SEL_W-1:0]                    wr_sel,
   input  logic [15:0]                         wr_limit,
   input  logic [ADDR_W-1:0]                   wr_base,
   output logic [NUM_TABLES-1:0][15:0]         limit_q,
   output logic [NUM_TABLES-1:0][ADDR_W-1:0]   base_q
);
   for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tab
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            limit_q[t] <= '0;
            base_q[t]  <= '0;
         end else if (wr_en && (wr_sel == SEL_W'(t))) begin
            limit_q[t] <= wr_limit;
            base_q[t]  <= wr_base;
         end
      end

      // R11
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && (wr_sel == SEL_W'(t))) |=> ($stable(limit_q[t]) && $stable(base_q[t])));
   end
endmodule

// File: rtl/dtr_load_unit.sv
module dtr_load_unit
   import dtr_pkg::*;
#(
   parameter int BEAT_W  = 16,
   parameter int ADDR_W  = 64,
   parameter int VA_BITS = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        modrm_reg,
   input  logic [2:0]        cpu_mode,
   input  logic              op32,
   input  logic [1:0]        cpl,
   input  logic              lock_pfx,
   input  logic              seg_is_ss,
   input  logic              seg_limit_err,
   input  logic              seg_null,
   input  logic              page_fault,
   input  logic [15:0]       pf_code,
   input  logic [63:0]       eff_addr,
   input  logic              rd_valid,
   input  logic [15:0]       rd_data,
   output logic              rd_ready,
   output logic [63:0]       rd_addr,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [7:0]        fault_vec,
   output logic              fault_err_vld,
   output logic [15:0]       fault_err,
   output logic [15:0]       gdt_limit,
   output logic [63:0]       gdt_base,
   output logic [15:0]       idt_limit,
   output logic [63:0]       idt_base
);
   localparam int BPB         = BEAT_W / 8;
   localparam int SHORT_BYTES = 6;
   localparam int LONG_BYTES  = 2 + ADDR_W / 8;
   localparam int SHORT_BEATS = (SHORT_BYTES + BPB - 1) / BPB;
   localparam int LONG_BEATS  = (LONG_BYTES + BPB - 1) / BPB;
   localparam int CNT_W       = $clog2(LONG_BEATS + 1);
   localparam int BUF_W       = LONG_BEATS * BEAT_W;

   if ((BEAT_W != 16) || (ADDR_W != 64)) begin : g_port_chk
      $error("dtr_load_unit: ports are fixed at 16-bit beats and 64-bit addresses");
   end
   if ((VA_BITS < 32) || (VA_BITS >= ADDR_W)) begin : g_va_chk
      $error("dtr_load_unit: VA_BITS must lie in [32, ADDR_W)");
   end

   fault_t            chk;
   logic              accept, go, commit_q, last_acc;
   logic              sel_q, long_q, op32_q;
   logic              done_q, fault_q, errv_q;
   logic [7:0]        vec_q;
   logic [15:0]       err_q;
   logic [BUF_W-1:0]  words;
   logic [CNT_W-1:0]  need;
   logic [15:0]       new_limit;
   logic [ADDR_W-1:0] new_base;
   logic [1:0][15:0]        limits;
   logic [1:0][ADDR_W-1:0]  bases;

   dtr_fault_check #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) i_check (
      .mode(cpu_mode), .reg_sel(modrm_reg), .cpl(cpl), .lock_pfx(lock_pfx),
      .seg_is_ss(seg_is_ss), .seg_limit_err(seg_limit_err), .seg_null(seg_null),
      .page_fault(page_fault), .pf_code(pf_code), .eff_addr(eff_addr), .result(chk)
   );

   assign accept = start && !busy;
   assign go     = accept && !chk.hit;
   assign need   = (cpu_mode == MODE_LONG) ? CNT_W'(LONG_BEATS) : CNT_W'(SHORT_BEATS);

   dtr_gather #(.BEAT_W(BEAT_W), .ADDR_W(ADDR_W), .MAX_BEATS(LONG_BEATS)) i_gather (
      .clk(clk), .rst_n(rst_n), .go(go), .need(need), .base_addr(eff_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready), .rd_addr(rd_addr),
      .last_acc(last_acc), .words(words)
   );

   assign new_limit = words[15:0];
   always_comb begin
      if (long_q)     new_base = words[16 +: ADDR_W];
      else if (op32_q) new_base = {{(ADDR_W-32){1'b0}}, words[47:16]};
      else            new_base = {{(ADDR_W-24){1'b0}}, words[39:16]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         commit_q <= 1'b0;
         sel_q    <= 1'b0;
         long_q   <= 1'b0;
         op32_q   <= 1'b0;
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
         vec_q    <= '0;
         errv_q   <= 1'b0;
         err_q    <= '0;
      end else begin
         commit_q <= last_acc;
         done_q   <= commit_q || (accept && chk.hit);
         fault_q  <= accept && chk.hit;
         if (accept && chk.hit) begin
            vec_q  <= chk.vec;
            errv_q <= chk.err_vld;
            err_q  <= chk.err;
         end
         if (go) begin
            sel_q  <= (modrm_reg == SEL_INTR);
            long_q <= (cpu_mode == MODE_LONG);
            op32_q <= op32;
         end
      end
   end

   dtr_table_regs #(.ADDR_W(ADDR_W), .NUM_TABLES(2)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(commit_q), .wr_sel(sel_q),
      .wr_limit(new_limit), .wr_base(new_base), .limit_q(limits), .base_q(bases)
   );

   assign busy          = rd_ready || commit_q;
   assign done          = done_q;
   assign fault         = fault_q;
   assign fault_vec     = vec_q;
   assign fault_err_vld = errv_q;
   assign fault_err     = err_q;
   assign gdt_limit     = limits[0];
   assign gdt_base      = bases[0];
   assign idt_limit     = limits[1];
   assign idt_base      = bases[1];

   // R11
   fault_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> done_q);
   // R11
   fault_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> !rd_ready);
   // R7
   lock_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && lock_pfx) |=> (fault_q && (fault_vec == VEC_UD) && !fault_err_vld));
   // R13
   commit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !fault_q) |-> $past(last_acc, 2));
endmodule

// File: tb/test_dtr_load_unit.sv
module test_dtr_load_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        start = 0, op32 = 0, lock_pfx = 0, seg_is_ss = 0, seg_limit_err = 0;
   logic        seg_null = 0, page_fault = 0, rd_valid = 0;
   logic [2:0]  modrm_reg = 0, cpu_mode = 0;
   logic [1:0]  cpl = 0;
   logic [15:0] pf_code = 0, rd_data;
   logic [63:0] eff_addr = 0;
   logic        rd_ready, busy, done, fault, fault_err_vld;
   logic [63:0] rd_addr, gdt_base, idt_base;
   logic [7:0]  fault_vec;
   logic [15:0] fault_err, gdt_limit, idt_limit;

   dtr_load_unit i_dtr_load_unit (.*);

   function automatic logic [15:0] mem_word(input logic [63:0] a);
      return (a[15:0] * 16'h9E37) ^ a[31:16] ^ a[63:48] ^ 16'hC5A1;
   endfunction
   assign rd_data = mem_word(rd_addr);

   int vectors = 0, miscompares = 0, cyc = 0;
   string cur_req = "R1";

   // reference model state
   logic [15:0] m_glim = 0, m_ilim = 0;
   logic [63:0] m_gbase = 0, m_ibase = 0;
   logic        m_gather = 0, m_commit = 0, e_done = 0, e_fault = 0, e_errv = 0;
   logic [7:0]  e_vec = 0;
   logic [15:0] e_err = 0;
   logic [15:0] w[5];
   int          m_cnt = 0, m_need = 0;
   logic [63:0] m_ea = 0;
   logic        m_sel = 0, m_long = 0, m_op32 = 0;

   function automatic void ref_fault(output logic hit, output logic [7:0] vec,
                                     output logic ev, output logic [15:0] er);
      logic canon;
      canon = (eff_addr[63:47] == '0) || (eff_addr[63:47] == '1);
      hit = 1; ev = 1; er = 0; vec = 0;
      if (lock_pfx || cpu_mode > 4 || !(modrm_reg == 2 || modrm_reg == 3)) begin vec = 6; ev = 0; end
      else if (cpu_mode != 0 && cpl != 0) vec = 13;
      else if (cpu_mode == 3 && !canon) vec = seg_is_ss ? 12 : 13;
      else if ((cpu_mode == 1 || cpu_mode == 2) && seg_limit_err) vec = seg_is_ss ? 12 : 13;
      else if (cpu_mode == 0 && seg_limit_err) begin vec = seg_is_ss ? 12 : 13; ev = 0; end
      else if ((cpu_mode == 1 || cpu_mode == 2) && seg_null && !seg_is_ss) vec = 13;
      else if (cpu_mode != 0 && page_fault) begin vec = 14; er = pf_code; end
      else begin hit = 0; ev = 0; end
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_gather = 0; m_commit = 0; e_done = 0; e_fault = 0;
      end else begin
         e_done = 0; e_fault = 0;
         if (m_commit) begin
            logic [63:0] b;
            if (m_long) b = {w[4], w[3], w[2], w[1]};
            else if (m_op32) b = {32'h0, w[2], w[1]};
            else b = {40'h0, w[2][7:0], w[1]};
            if (m_sel) begin m_ilim = w[0]; m_ibase = b; end
            else begin m_glim = w[0]; m_gbase = b; end
            e_done = 1; m_commit = 0;
         end else if (m_gather) begin
            if (rd_valid) begin
               w[m_cnt] = mem_word(m_ea + 64'(2 * m_cnt));
               m_cnt++;
               if (m_cnt == m_need) begin m_gather = 0; m_commit = 1; end
            end
         end else if (start) begin
            logic h, ev; logic [7:0] v; logic [15:0] er;
            ref_fault(h, v, ev, er);
            if (h) begin e_done = 1; e_fault = 1; e_vec = v; e_errv = ev; e_err = er; end
            else begin
               m_gather = 1; m_cnt = 0; m_ea = eff_addr;
               m_need = (cpu_mode == 3) ? 5 : 3;
               m_sel = (modrm_reg == 3); m_long = (cpu_mode == 3); m_op32 = op32;
            end
         end
      end
   end

   task automatic cmp(input string what, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cyc > 2) begin
         cmp("done", done, e_done);
         cmp("fault", fault, e_fault);
         cmp("rd_ready", rd_ready, m_gather);
         cmp("busy", busy, m_gather | m_commit);
         if (m_gather) cmp("rd_addr", rd_addr, m_ea + 64'(2 * m_cnt));
         if (e_fault) begin
            cmp("fault_vec", fault_vec, e_vec);
            cmp("fault_err_vld", fault_err_vld, e_errv);
            if (e_errv) cmp("fault_err", fault_err, e_err);
         end
         cmp("gdt_limit", gdt_limit, m_glim);
         cmp("gdt_base", gdt_base, m_gbase);
         cmp("idt_limit", idt_limit, m_ilim);
         cmp("idt_base", idt_base, m_ibase);
      end
   end

   // stall pattern on the read port
   always @(negedge clk) rd_valid <= (cyc % 4) != 2;

   task automatic run(input string req, input logic [2:0] mode, input logic [2:0] rg,
                      input logic o32, input logic [1:0] pl, input logic [63:0] ea);
      cur_req = req;
      @(negedge clk);
      cpu_mode = mode; modrm_reg = rg; op32 = o32; cpl = pl; eff_addr = ea;
      start = 1;
      @(negedge clk);
      start = 0;
      for (int i = 0; i < 100 && !done; i++) @(negedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL %s done: actual 0 expected 1", req);
      end
      @(negedge clk);
      lock_pfx = 0; seg_is_ss = 0; seg_limit_err = 0; seg_null = 0; page_fault = 0; pf_code = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      cmp("reset gdt", {gdt_limit, gdt_base[47:0]}, 64'h0);
      cmp("reset idt", {idt_limit, idt_base[47:0]}, 64'h0);
      cmp("reset flags", {busy, done, fault, rd_ready}, 64'h0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      run("R4", 3'd1, 3'd2, 1, 0, 64'h1000);
      run("R3", 3'd1, 3'd2, 1, 0, 64'h2468);
      run("R2", 3'd1, 3'd3, 1, 0, 64'h3000);
      run("R5", 3'd0, 3'd2, 0, 3, 64'h0000_7A02);
      run("R5", 3'd2, 3'd3, 0, 0, 64'h0000_5550);
      run("R6", 3'd3, 3'd3, 0, 0, 64'hFFFF_8000_0000_0100);
      run("R6", 3'd3, 3'd2, 1, 0, 64'h0000_7FFF_FFF0_0000);
      lock_pfx = 1; run("R7", 3'd3, 3'd2, 1, 0, 64'h100);
      lock_pfx = 1; run("R7", 3'd0, 3'd3, 0, 0, 64'h100);
      run("R2", 3'd1, 3'd5, 1, 0, 64'h100);
      run("R8", 3'd1, 3'd2, 1, 3, 64'h100);
      run("R8", 3'd4, 3'd3, 0, 1, 64'h100);
      seg_is_ss = 1; run("R9", 3'd3, 3'd2, 1, 0, 64'h0001_0000_0000_0000);
      run("R9", 3'd3, 3'd3, 1, 0, 64'h8000_0000_0000_0000);
      seg_is_ss = 1; seg_limit_err = 1; run("R10", 3'd1, 3'd2, 1, 0, 64'h100);
      seg_null = 1; run("R10", 3'd2, 3'd3, 1, 0, 64'h100);
      seg_limit_err = 1; run("R10", 3'd0, 3'd2, 0, 0, 64'h100);
      seg_is_ss = 1; seg_null = 1; run("R10", 3'd1, 3'd2, 1, 0, 64'h4400);
      lock_pfx = 1; page_fault = 1; run("R11", 3'd1, 3'd2, 1, 2, 64'h100);
      seg_limit_err = 1; page_fault = 1; run("R11", 3'd1, 3'd3, 1, 1, 64'h100);
      page_fault = 1; seg_null = 1; run("R11", 3'd2, 3'd2, 1, 0, 64'h100);
      page_fault = 1; pf_code = 16'h0005; run("R12", 3'd1, 3'd2, 1, 0, 64'h100);
      page_fault = 1; run("R12", 3'd0, 3'd3, 1, 0, 64'h6600);
      // R13: start held while busy must not restart the fetch
      cur_req = "R13";
      @(negedge clk);
      cpu_mode = 3'd1; modrm_reg = 3'd3; op32 = 1; cpl = 0; eff_addr = 64'h9A00;
      start = 1;
      repeat (3) @(negedge clk);
      eff_addr = 64'hBEE0;
      for (int i = 0; i < 100 && !done; i++) @(negedge clk);
      start = 0;
      repeat (20) @(negedge clk);
      run("R13", 3'd3, 3'd2, 0, 0, 64'h0000_0000_00AB_CD00);
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #1000000;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule